// File: doc/BRIEF.md
# DMA Controller Global Register Bank and Interrupt Combiner

This block holds the registers that a multi-channel DMA controller shares across all of its channels, and sits between a simple register bus and up to 32 channel blocks. It decodes each bus address into one of three kinds. An address may hit a channel bank, where each channel owns a fixed 32-byte window starting at zero. It may hit one of four global registers at 0x1000. Otherwise it is unmapped. Channel accesses are forwarded to the selected channel over plain one-hot select, offset and write-data ports, and the selected channel's read data is returned on the bus.

The global registers are a control word, a per-channel interrupt-pending word, a read-only doorbell word and a doorbell-set port. The control word holds four things: a controller enable, sticky address-error and halt flags, and five stored fast-transfer mode flags. The enable is sequenced by a small state machine with three states. EN_OFF moves to EN_WAKE on a write with bit 0 set. EN_WAKE moves to EN_ON unless the same cycle writes bit 0 clear, in which case it returns to EN_OFF. EN_ON returns to EN_OFF on any control write with bit 0 clear. The enable bit reads back as 1 only in EN_ON.

Channel completion pulses accumulate in the pending word. One interrupt line reports the OR of the pending bits while the controller is in EN_ON. Doorbell bits start descriptor fetches. Software raises them only through the set port. A channel clears its own doorbell bit with an acknowledge pulse.

Top module: `dmac_glob_ctl`

## Requirements
- R1: An address below NCH×0x20 selects channel addr[9:5]. It drives that bit alone in `ch_sel_o` and sets `ch_we_o` for writes. The bus read data is then `ch_rdata_i`. `ch_off_o` carries addr[4:0] at all times. Any other address selects no channel.
- R2: The global registers decode at 0x1000 (control), 0x1004 (pending), 0x1008 (doorbell) and 0x100C (doorbell-set). The doorbell-set port reads 0. Unmapped addresses read 0, and all global registers read 0 after reset.
- R3: Control bit 0 reads 0 in the cycle after a write of 1 and reads 1 from the following cycle on. A write of 0 clears it at the next edge.
- R4: Control bit 2 (address error) is set by `err_evt_i` and bit 3 (halt) is set by `halt_evt_i`. A control write with the bit at 0 clears it. A write with the bit at 1 neither sets nor clears it. An event in the same cycle as a clearing write leaves the bit set.
- R5: Control bits 31:27 store the written value and read it back. Bits 26:4 and bit 1 read 0.
- R6: A pulse on `ch_done_i[n]` sets pending bit n. A pending write clears each bit written 0 and leaves each bit written 1 unchanged.
- R7: A completion pulse in the same cycle as a write that clears that pending bit leaves the bit set.
- R8: A write of 1 to doorbell-set bit n sets doorbell bit n, and bits written 0 have no effect. Writes to the doorbell register at 0x1008 change nothing.
- R9: A pulse on `ch_db_ack_i[n]` clears doorbell bit n. A set of the same bit in the same cycle wins.
- R10: `irq_o` is 1 exactly when the controller reads enabled and at least one pending bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| bus_valid_i | input | 1 | Bus access strobe |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | AW | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data (combinational) |
| ch_sel_o | output | NCH | One-hot channel bank select |
| ch_we_o | output | 1 | Write strobe to the selected channel |
| ch_off_o | output | 5 | Offset within the channel bank |
| ch_wdata_o | output | 32 | Write data to channels |
| ch_rdata_i | input | 32 | Read data from the selected channel |
| ch_done_i | input | NCH | Per-channel completion pulses |
| ch_db_ack_i | input | NCH | Per-channel fetch-start acknowledges |
| ch_db_o | output | NCH | Doorbell bits to channels |
| err_evt_i | input | 1 | Address-error event |
| halt_evt_i | input | 1 | Halt event |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench sweeps every word address through the channel region, the unmapped gap and the global window. A decoder off by one bank, or one that decoded the global window too broadly, would select the wrong channel or return nonzero data for a hole. Each of the 16 pending and doorbell masks is written in turn, which exposes an acknowledge scheme that clears bits written 1, or a doorbell that the plain doorbell address can alter. The same-cycle races are driven directly: event against clear, completion against acknowledge-write, and doorbell set against channel acknowledge. A design that let the clear win would lose an interrupt or a fetch request. The enable sequence is sampled both in EN_WAKE and in EN_ON, so a controller that reported enabled one cycle early would be caught.

// File: rtl/dmac_pkg.sv
`timescale 1ns/1ps
package dmac_pkg;
    typedef enum logic [1:0] {
        EN_OFF  = 2'd0,
        EN_WAKE = 2'd1,
        EN_ON   = 2'd2
    } en_state_t;

    // global register index (address bits 3:2 inside the global window)
    localparam logic [1:0] GI_CTRL  = 2'd0;
    localparam logic [1:0] GI_PEND  = 2'd1;
    localparam logic [1:0] GI_DBELL = 2'd2;
    localparam logic [1:0] GI_DBSET = 2'd3;

    // control word bit positions
    localparam int CB_EN    = 0;
    localparam int CB_ERR   = 2;
    localparam int CB_HALT  = 3;
    localparam int CB_FAST  = 27;
    localparam int FAST_W   = 5;

    localparam int BANK_BYTES = 32;
    localparam int GLOB_BASE  = 32'h1000;
endpackage

// File: rtl/dmac_addr_dec.sv
`timescale 1ns/1ps
module dmac_addr_dec #(
    parameter int NCH = 32,
    parameter int AW  = 13
) (
    input  logic           valid_i,
    input  logic [AW-1:0]  addr_i,
    output logic           glob_hit_o,
    output logic [1:0]     glob_idx_o,
    output logic           ch_hit_o,
    output logic [NCH-1:0] ch_sel_o
);
    import dmac_pkg::*;
    localparam int CHW = $clog2(NCH);
    localparam int OFFW = $clog2(BANK_BYTES);
    localparam logic [AW-1:0] CH_SPAN = AW'(NCH * BANK_BYTES);
    localparam logic [AW-1:0] GBASE   = AW'(GLOB_BASE);

    assign ch_hit_o   = valid_i && (addr_i < CH_SPAN);
    assign glob_hit_o = valid_i && ((addr_i >> 4) == (GBASE >> 4));
    assign glob_idx_o = addr_i[3:2];

    for (genvar i = 0; i < NCH; i++) begin : g_sel
        assign ch_sel_o[i] = ch_hit_o && (addr_i[OFFW+CHW-1:OFFW] == CHW'(i));
    end
endmodule

// File: rtl/dmac_en_fsm.sv
`timescale 1ns/1ps
module dmac_en_fsm (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 ctrl_wr_i,
    input  logic                 en_bit_i,
    output dmac_pkg::en_state_t  state_o,
    output logic                 active_o
);
    import dmac_pkg::*;
    en_state_t state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= EN_OFF;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EN_OFF:  if (ctrl_wr_i && en_bit_i) state_d = EN_WAKE;
            EN_WAKE: state_d = (ctrl_wr_i && !en_bit_i) ? EN_OFF : EN_ON;
            EN_ON:   if (ctrl_wr_i && !en_bit_i) state_d = EN_OFF;
            default: state_d = EN_OFF;
        endcase
    end

    always_comb begin
        state_o  = state_q;
        active_o = (state_q == EN_ON);
    end
endmodule

// File: rtl/dmac_chan_flags.sv
`timescale 1ns/1ps
module dmac_chan_flags #(
    parameter int NCH = 32
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           pend_wr_i,
    input  logic           dbset_wr_i,
    input  logic [NCH-1:0] wmask_i,
    input  logic [NCH-1:0] done_i,
    input  logic [NCH-1:0] ack_i,
    output logic [NCH-1:0] pend_o,
    output logic [NCH-1:0] db_o
);
    for (genvar n = 0; n < NCH; n++) begin : g_ch
        logic pend_q, db_q;
        logic clr_pend, set_db;
        assign clr_pend = pend_wr_i && !wmask_i[n];
        assign set_db   = dbset_wr_i && wmask_i[n];

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                pend_q <= 1'b0;
                db_q   <= 1'b0;
            end else begin
                pend_q <= done_i[n] | (pend_q & ~clr_pend);
                db_q   <= set_db | (db_q & ~ack_i[n]);
            end
        end
        assign pend_o[n] = pend_q;
        assign db_o[n]   = db_q;
    end
endmodule

// File: rtl/dmac_glob_ctl.sv
`timescale 1ns/1ps
module dmac_glob_ctl #(
    parameter int NCH = 32,
    parameter int AW  = 13
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           bus_valid_i,
    input  logic           bus_write_i,
    input  logic [AW-1:0]  bus_addr_i,
    input  logic [31:0]    bus_wdata_i,
    output logic [31:0]    bus_rdata_o,
    output logic [NCH-1:0] ch_sel_o,
    output logic           ch_we_o,
    output logic [4:0]     ch_off_o,
    output logic [31:0]    ch_wdata_o,
    input  logic [31:0]    ch_rdata_i,
    input  logic [NCH-1:0] ch_done_i,
    input  logic [NCH-1:0] ch_db_ack_i,
    output logic [NCH-1:0] ch_db_o,
    input  logic           err_evt_i,
    input  logic           halt_evt_i,
    output logic           irq_o
);
    import dmac_pkg::*;

    logic           glob_hit, ch_hit;
    logic [1:0]     glob_idx;
    logic           gwr, ctrl_wr, pend_wr, dbset_wr;
    en_state_t      en_state;
    logic           en_active;
    logic [NCH-1:0] pend_q;
    logic           err_q, halt_q;
    logic [FAST_W-1:0] fast_q;

    dmac_addr_dec #(.NCH(NCH), .AW(AW)) u_dec (
        .valid_i    (bus_valid_i),
        .addr_i     (bus_addr_i),
        .glob_hit_o (glob_hit),
        .glob_idx_o (glob_idx),
        .ch_hit_o   (ch_hit),
        .ch_sel_o   (ch_sel_o)
    );

    assign gwr      = glob_hit && bus_write_i;
    assign ctrl_wr  = gwr && (glob_idx == GI_CTRL);
    assign pend_wr  = gwr && (glob_idx == GI_PEND);
    assign dbset_wr = gwr && (glob_idx == GI_DBSET);

    assign ch_we_o    = ch_hit && bus_write_i;
    assign ch_off_o   = bus_addr_i[4:0];
    assign ch_wdata_o = bus_wdata_i;

    dmac_en_fsm u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ctrl_wr_i (ctrl_wr),
        .en_bit_i  (bus_wdata_i[CB_EN]),
        .state_o   (en_state),
        .active_o  (en_active)
    );

    dmac_chan_flags #(.NCH(NCH)) u_flags (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .pend_wr_i  (pend_wr),
        .dbset_wr_i (dbset_wr),
        .wmask_i    (bus_wdata_i[NCH-1:0]),
        .done_i     (ch_done_i),
        .ack_i      (ch_db_ack_i),
        .pend_o     (pend_q),
        .db_o       (ch_db_o)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            err_q  <= 1'b0;
            halt_q <= 1'b0;
            fast_q <= '0;
        end else begin
            err_q  <= err_evt_i  | (err_q  & ~(ctrl_wr & ~bus_wdata_i[CB_ERR]));
            halt_q <= halt_evt_i | (halt_q & ~(ctrl_wr & ~bus_wdata_i[CB_HALT]));
            if (ctrl_wr) fast_q <= bus_wdata_i[CB_FAST +: FAST_W];
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        if (ch_hit) begin
            bus_rdata_o = ch_rdata_i;
        end else if (glob_hit) begin
            unique case (glob_idx)
                GI_CTRL: begin
                    bus_rdata_o[CB_FAST +: FAST_W] = fast_q;
                    bus_rdata_o[CB_HALT] = halt_q;
                    bus_rdata_o[CB_ERR]  = err_q;
                    bus_rdata_o[CB_EN]   = en_active;
                end
                GI_PEND:  bus_rdata_o[NCH-1:0] = pend_q;
                GI_DBELL: bus_rdata_o[NCH-1:0] = ch_db_o;
                default:  bus_rdata_o = '0;
            endcase
        end
    end

    assign irq_o = en_active && (|pend_q);
endmodule

// File: rtl/dmac_glob_ctl_chk.sv
`timescale 1ns/1ps
module dmac_glob_ctl_chk #(
    parameter int NCH = 32
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                irq_o,
    input logic                en_active,
    input dmac_pkg::en_state_t en_state,
    input logic [NCH-1:0]      ch_sel_o,
    input logic [NCH-1:0]      ch_done_i,
    input logic [NCH-1:0]      pend_q
);
    import dmac_pkg::*;

    p_sel_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(ch_sel_o));

    p_irq_gated_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> en_active);

    p_wake_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(en_active) |-> ($past(en_state) == EN_WAKE));

    p_done_sticks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|ch_done_i) |=> ((pend_q & $past(ch_done_i)) == $past(ch_done_i)));
endmodule

bind dmac_glob_ctl dmac_glob_ctl_chk #(.NCH(NCH)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .irq_o     (irq_o),
    .en_active (en_active),
    .en_state  (en_state),
    .ch_sel_o  (ch_sel_o),
    .ch_done_i (ch_done_i),
    .pend_q    (pend_q)
);

// File: tb/test_dmac_glob_ctl.sv
`timescale 1ns/1ps
module test_dmac_glob_ctl;
    localparam int NCH = 4;
    localparam int AW  = 13;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bvalid = 0, bwrite = 0;
    logic [AW-1:0] baddr = '0;
    logic [31:0] bwdata = '0, brdata, cwdata, crdata = '0;
    logic [NCH-1:0] csel, cdone = '0, cack = '0, cdb;
    logic cwe, errev = 0, haltev = 0, irq;
    logic [4:0] coff;

    int n_chk = 0, n_fail = 0;
    bit done_flag = 0;

    always #4 clk = ~clk;

    dmac_glob_ctl #(.NCH(NCH), .AW(AW)) i_dmac_glob_ctl (
        .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(bvalid), .bus_write_i(bwrite),
        .bus_addr_i(baddr), .bus_wdata_i(bwdata), .bus_rdata_o(brdata),
        .ch_sel_o(csel), .ch_we_o(cwe), .ch_off_o(coff), .ch_wdata_o(cwdata),
        .ch_rdata_i(crdata), .ch_done_i(cdone), .ch_db_ack_i(cack), .ch_db_o(cdb),
        .err_evt_i(errev), .halt_evt_i(haltev), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // one clock of stimulus: bus op plus side events, all in the same cycle
    task automatic cyc(input logic v, input logic w, input logic [AW-1:0] a, input logic [31:0] d,
                       input logic [NCH-1:0] dn, input logic [NCH-1:0] ak, input logic e, input logic h);
        @(negedge clk);
        bvalid = v; bwrite = w; baddr = a; bwdata = d;
        cdone = dn; cack = ak; errev = e; haltev = h;
        @(negedge clk);
        bvalid = 0; bwrite = 0; cdone = '0; cack = '0; errev = 0; haltev = 0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        cyc(1, 1, a, d, '0, '0, 0, 0);
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        bvalid = 1; bwrite = 0; baddr = a;
        #1 d = brdata;
        bvalid = 0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done_flag) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r, ctl;
        logic [NCH-1:0] pm;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R2: reset values
        rd(13'h1000, r); chk("R2 ctrl reset", r, 0);
        rd(13'h1004, r); chk("R2 pend reset", r, 0);
        rd(13'h1008, r); chk("R2 dbell reset", r, 0);
        chk("R10 irq reset", {31'd0, irq}, 0);

        // R1/R2: sweep every word address
        crdata = 32'hC0DE_5A5A;
        for (int a = 0; a < 13'h1080; a += 4) begin
            logic [NCH-1:0] es;
            es = (a < NCH * 32) ? NCH'(1 << (a >> 5)) : '0;
            rd(AW'(a), r);
            bvalid = 1; baddr = AW'(a); #1;
            chk("R1 sel", {28'd0, csel}, {28'd0, es});
            chk("R1 off", {27'd0, coff}, 32'(a & 31));
            bvalid = 0;
            chk("R1 R2 rdata", r, (a < NCH * 32) ? crdata : 32'd0);
        end
        bvalid = 1; bwrite = 1; baddr = 13'h064; #1;
        chk("R1 we", {31'd0, cwe}, 1);
        baddr = 13'h1000; #1;
        chk("R1 we global", {31'd0, cwe}, 0);
        bvalid = 0; bwrite = 0;

        // R3: enable sequence
        wr(13'h1000, 32'h1);
        rd(13'h1000, r); chk("R3 wake", r & 1, 0);
        @(negedge clk);
        rd(13'h1000, r); chk("R3 on", r & 1, 1);
        wr(13'h1000, 32'h0);
        rd(13'h1000, r); chk("R3 off", r & 1, 0);
        wr(13'h1000, 32'h1); @(negedge clk);

        // R5: fast flag sweep, enable kept on
        for (int v = 0; v < 32; v++) begin
            wr(13'h1000, (32'(v) << 27) | 32'h0012_3452 | 32'h1);
            rd(13'h1000, r); chk("R5 fast", r, (32'(v) << 27) | 32'h1);
        end
        ctl = 32'hF800_0001;

        // R4: error and halt flags
        cyc(0, 0, '0, 0, '0, '0, 1, 0);
        rd(13'h1000, r); chk("R4 err set", r, ctl | 32'h4);
        wr(13'h1000, ctl | 32'hC);
        rd(13'h1000, r); chk("R4 write1 keeps", r, ctl | 32'h4);
        cyc(0, 0, '0, 0, '0, '0, 0, 1);
        rd(13'h1000, r); chk("R4 halt set", r, ctl | 32'hC);
        wr(13'h1000, ctl | 32'h8);
        rd(13'h1000, r); chk("R4 err clear", r, ctl | 32'h8);
        cyc(1, 1, 13'h1000, ctl, '0, '0, 0, 1);
        rd(13'h1000, r); chk("R4 halt event wins", r, ctl | 32'h8);
        wr(13'h1000, ctl);
        rd(13'h1000, r); chk("R4 both clear", r, ctl);
        wr(13'h1000, ctl | 32'h4);
        rd(13'h1000, r); chk("R4 write1 no set", r, ctl);

        // R6/R10: pending accumulation and irq
        pm = '0;
        for (int n = 0; n < NCH; n++) begin
            cyc(0, 0, '0, 0, NCH'(1 << n), '0, 0, 0);
            pm |= NCH'(1 << n);
            rd(13'h1004, r); chk("R6 pend set", r, 32'(pm));
            chk("R10 irq on", {31'd0, irq}, 1);
        end
        // R6: every write-back mask
        for (int m = 0; m < 16; m++) begin
            cyc(0, 0, '0, 0, '1, '0, 0, 0);
            wr(13'h1004, 32'(m));
            rd(13'h1004, r); chk("R6 ack mask", r, 32'(m));
            chk("R10 irq mask", {31'd0, irq}, (m != 0) ? 1 : 0);
        end
        // R7: completion races clear
        cyc(1, 1, 13'h1004, 32'h0, 4'b0100, '0, 0, 0);
        rd(13'h1004, r); chk("R7 set wins", r, 32'h4);
        // R10: disable gates irq
        wr(13'h1000, 32'h0);
        chk("R10 irq disabled", {31'd0, irq}, 0);
        wr(13'h1000, 32'h1);
        chk("R10 irq wake", {31'd0, irq}, 0);
        @(negedge clk);
        chk("R10 irq reenabled", {31'd0, irq}, 1);
        wr(13'h1004, 0);

        // R8/R9: doorbell masks
        for (int m = 0; m < 16; m++) begin
            cyc(0, 0, '0, 0, '0, '1, 0, 0);
            wr(13'h100C, 32'(m));
            rd(13'h1008, r); chk("R8 dbset", r, 32'(m));
            chk("R8 db port", {28'd0, cdb}, 32'(m));
            rd(13'h100C, r); chk("R2 dbset reads 0", r, 0);
            wr(13'h1008, 32'(~m & 15));
            rd(13'h1008, r); chk("R8 dbell write ignored", r, 32'(m));
        end
        cyc(0, 0, '0, 0, '0, 4'b0011, 0, 0);
        rd(13'h1008, r); chk("R9 ack clears", r, 32'hC);
        cyc(1, 1, 13'h100C, 32'h1, '0, 4'b1001, 0, 0);
        rd(13'h1008, r); chk("R9 set wins ack", r, 32'h5);

        done_flag = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule